// File: doc/BRIEF.md
# BPSK Reply Frame Transmitter

This block builds the answer a contactless tag sends back to its reader. It produces the drive for the load-modulation switch. The block derives a reply carrier by halving the received carrier. It then sends each reply bit as one of two phases of that reply carrier, and each bit lasts a fixed number of received-carrier cycles.

The data-processing logic starts a reply with a one-cycle `start` pulse and supplies a status byte and a byte count with it. The status byte goes out first, as eight bare bits. When the status is zero, the requested number of payload bytes follows. Each payload byte has a low start bit, the data bits, a parity bit and a high stop bit. When the status is nonzero, each set bit flags a fault, so the reply ends after the status byte. Payload bytes are pulled one at a time through a single-cycle request pulse. `busy` tells the command logic when the modulator owns the antenna.

Top module: `bpsk_reply_tx`

## Requirements
- R1: While `busy` is high, `mod_out` changes level on every rising edge of the received carrier, so the reply carrier runs at half the received-carrier frequency.
- R2: A reply bit lasts EDGES_PER_BIT (default 16) received-carrier rising edges, which is 8 reply-carrier cycles.
- R3: In the first received-carrier interval of every bit, the reply-carrier reference is low. A logic 1 leaves the reference uninverted (so `mod_out` is 0 in that interval). A logic 0 inverts it for the whole bit (so `mod_out` is 1).
- R4: Every reply opens with the 8 status bits, least significant first, with no start, parity or stop bit around them.
- R5: When the status is 00h, `byte_count` payload bytes follow. Each byte is sent as a start bit (0), the 8 data bits least significant first, an even-parity bit (the XOR of the data bits), and a stop bit (1).
- R6: When the status is nonzero, the reply ends after the status byte, and `byte_req` never pulses.
- R7: A status of 00h with a byte count of zero sends the status byte alone.
- R8: `busy` rises as the first status bit begins and falls exactly when the last bit ends. Its high time is therefore the bit count times EDGES_PER_BIT carrier periods. `mod_out` stays low whenever `busy` is low.
- R9: `byte_req` is a one-cycle pulse. It is issued at the start of the last status bit and at the start of every stop bit that has another byte after it. `byte_data` is captured in the cycle where `byte_req` is high. Over a reply, the number of pulses equals the number of bytes sent.
- R10: A `start` pulse that arrives while a reply is pending or in progress is ignored. It changes neither the current frame nor its length.
- R11: After `start` is accepted, the frame begins on the first received-carrier rising edge seen after synchronization.
- R12: After reset, `busy`, `mod_out` and `byte_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the received carrier |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_in | input | 1 | Squared received carrier, asynchronous to `clk` |
| start | input | 1 | One-cycle request to send a reply |
| status_in | input | DATA_W | Status byte, captured with `start` |
| count_in | input | CNT_W | Number of payload bytes, captured with `start` |
| byte_data | input | DATA_W | Next payload byte, captured while `byte_req` is high |
| byte_req | output | 1 | One-cycle request for the next payload byte |
| busy | output | 1 | High for the full duration of a reply frame |
| mod_out | output | 1 | Load-modulation drive |

## Verification
The assertions rely on three assumptions about the inputs. First, `carrier_in` stays at each level for more clock cycles than the synchronizer depth, so every carrier edge is seen exactly once. Second, `start` lasts a single cycle. Third, `byte_data` already holds the next byte in the cycle where `byte_req` is high. The stimulus drives a carrier with four clocks per half period. It moves to the next payload byte only on the falling clock edge after the request cycle, so the captured value is never in transition. It raises `start` for exactly one cycle, including the deliberate extra pulse it places in the middle of a frame.

// File: rtl/bpsk_tx_pkg.sv
package bpsk_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_ARMED = 2'd1,
      TX_SEND  = 2'd2
   } tx_state_e;

   typedef enum logic [2:0] {
      FR_STATUS = 3'd0,
      FR_START  = 3'd1,
      FR_DATA   = 3'd2,
      FR_PARITY = 3'd3,
      FR_STOP   = 3'd4
   } frame_phase_e;

endpackage

// File: rtl/bpsk_carrier_timer.sv
module bpsk_carrier_timer #(
   parameter int SYNC_STAGES   = 2,
   parameter int EDGES_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic carrier_in,
   input  logic run,
   output logic edge_seen,
   output logic ref_phase,
   output logic bit_end
);
   localparam int CW = (EDGES_PER_BIT > 2) ? $clog2(EDGES_PER_BIT) : 1;
   localparam logic [CW-1:0] LAST_EDGE = CW'(EDGES_PER_BIT - 1);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (EDGES_PER_BIT < 2 || (EDGES_PER_BIT % 2) != 0) begin : g_bad_epb
      $error("EDGES_PER_BIT must be even and at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic [CW-1:0]          edge_cnt_q;
   logic                   div_q;

   if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= carrier_in;
      end
   end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], carrier_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign edge_seen = sync_q[SYNC_STAGES-1] & ~last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt_q <= '0;
         div_q      <= 1'b0;
      end else if (edge_seen) begin
         if (!run) begin
            edge_cnt_q <= '0;
            div_q      <= 1'b0;
         end else begin
            div_q      <= ~div_q;
            edge_cnt_q <= (edge_cnt_q == LAST_EDGE) ? '0 : edge_cnt_q + 1'b1;
         end
      end
   end

   assign ref_phase = div_q;
   assign bit_end   = edge_seen & run & (edge_cnt_q == LAST_EDGE);

   // R1: reply carrier flips on each received edge while running
   p_phase_flips_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_seen && run) |=> (ref_phase != $past(ref_phase)));

   // R3: every bit starts with the reference low
   p_bit_starts_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_end |=> !ref_phase);

endmodule

// File: rtl/bpsk_frame_seq.sv
module bpsk_frame_seq
   import bpsk_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] status_in,
   input  logic [CNT_W-1:0]  count_in,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              edge_seen,
   input  logic              bit_end,
   output logic              send,
   output logic              tx_bit,
   output logic              byte_req
);
   localparam int IW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);
   localparam logic [IW-1:0] PRE_IDX  = IW'(DATA_W - 2);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   tx_state_e     state_q;
   frame_phase_e  phase_q;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] shift_q;
   logic [DATA_W-1:0] next_q;
   logic [CNT_W-1:0]  left_q;
   logic [IW-1:0]     idx_q;
   logic              par_q;
   logic              req_q;
   logic              par_calc;
   logic              more_data;

   if (ODD_PARITY) begin : g_par_odd
      assign par_calc = ~^next_q;
   end else begin : g_par_even
      assign par_calc = ^next_q;
   end

   assign more_data = (status_q == '0) && (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= TX_IDLE;
         phase_q  <= FR_STATUS;
         status_q <= '0;
         shift_q  <= '0;
         next_q   <= '0;
         left_q   <= '0;
         idx_q    <= '0;
         par_q    <= 1'b0;
         req_q    <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (req_q) next_q <= byte_data;
         unique case (state_q)
            TX_IDLE: begin
               if (start) begin
                  status_q <= status_in;
                  left_q   <= count_in;
                  state_q  <= TX_ARMED;
               end
            end
            TX_ARMED: begin
               if (edge_seen) begin
                  state_q <= TX_SEND;
                  phase_q <= FR_STATUS;
                  idx_q   <= '0;
                  shift_q <= status_q;
               end
            end
            TX_SEND: begin
               if (bit_end) begin
                  unique case (phase_q)
                     FR_STATUS: begin
                        if (idx_q == PRE_IDX && more_data) req_q <= 1'b1;
                        if (idx_q == LAST_IDX) begin
                           if (more_data) begin
                              phase_q <= FR_START;
                              left_q  <= left_q - 1'b1;
                           end else begin
                              state_q <= TX_IDLE;
                           end
                        end else begin
                           idx_q   <= idx_q + 1'b1;
                           shift_q <= shift_q >> 1;
                        end
                     end
                     FR_START: begin
                        phase_q <= FR_DATA;
                        idx_q   <= '0;
                        shift_q <= next_q;
                        par_q   <= par_calc;
                     end
                     FR_DATA: begin
                        if (idx_q == LAST_IDX) begin
                           phase_q <= FR_PARITY;
                        end else begin
                           idx_q   <= idx_q + 1'b1;
                           shift_q <= shift_q >> 1;
                        end
                     end
                     FR_PARITY: begin
                        phase_q <= FR_STOP;
                        if (left_q != '0) req_q <= 1'b1;
                     end
                     FR_STOP: begin
                        if (left_q != '0) begin
                           phase_q <= FR_START;
                           left_q  <= left_q - 1'b1;
                        end else begin
                           state_q <= TX_IDLE;
                        end
                     end
                     default: state_q <= TX_IDLE;
                  endcase
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (phase_q)
         FR_START:  tx_bit = 1'b0;
         FR_PARITY: tx_bit = par_q;
         FR_STOP:   tx_bit = 1'b1;
         default:   tx_bit = shift_q[0];
      endcase
   end

   assign send     = (state_q == TX_SEND);
   assign byte_req = req_q;

   // R9: a byte request is a single-cycle pulse
   p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);

   // R6: no payload is requested after a fault status
   p_req_needs_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> (status_q == '0));

   // R5: a start bit only follows the status byte or a stop bit
   p_start_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == FR_START && $past(phase_q) != FR_START)
         |-> ($past(phase_q) == FR_STATUS || $past(phase_q) == FR_STOP));

   // R10: a start outside idle leaves the captured status alone
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != TX_IDLE && start) |=> (status_q == $past(status_q)));

endmodule

// File: rtl/bpsk_phase_mod.sv
module bpsk_phase_mod #(
   parameter bit INVERT_ON_ZERO = 1'b1
) (
   input  logic send,
   input  logic ref_phase,
   input  logic tx_bit,
   output logic mod_out
);
   logic flip;

   if (INVERT_ON_ZERO) begin : g_inv_zero
      assign flip = ~tx_bit;
   end else begin : g_inv_one
      assign flip = tx_bit;
   end

   assign mod_out = send & (ref_phase ^ flip);

endmodule

// File: rtl/bpsk_reply_tx.sv
module bpsk_reply_tx #(
   parameter int DATA_W         = 8,
   parameter int CNT_W          = 8,
   parameter int EDGES_PER_BIT  = 16,
   parameter int SYNC_STAGES    = 2,
   parameter bit ODD_PARITY     = 1'b0,
   parameter bit INVERT_ON_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              carrier_in,
   input  logic              start,
   input  logic [DATA_W-1:0] status_in,
   input  logic [CNT_W-1:0]  count_in,
   input  logic [DATA_W-1:0] byte_data,
   output logic              byte_req,
   output logic              busy,
   output logic              mod_out
);
   logic edge_w;
   logic phase_w;
   logic bit_end_w;
   logic send_w;
   logic bit_w;

   bpsk_carrier_timer #(
      .SYNC_STAGES  (SYNC_STAGES),
      .EDGES_PER_BIT(EDGES_PER_BIT)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .carrier_in(carrier_in),
      .run       (send_w),
      .edge_seen (edge_w),
      .ref_phase (phase_w),
      .bit_end   (bit_end_w)
   );

   bpsk_frame_seq #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .ODD_PARITY(ODD_PARITY)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .status_in(status_in),
      .count_in (count_in),
      .byte_data(byte_data),
      .edge_seen(edge_w),
      .bit_end  (bit_end_w),
      .send     (send_w),
      .tx_bit   (bit_w),
      .byte_req (byte_req)
   );

   bpsk_phase_mod #(
      .INVERT_ON_ZERO(INVERT_ON_ZERO)
   ) u_mod (
      .send     (send_w),
      .ref_phase(phase_w),
      .tx_bit   (bit_w),
      .mod_out  (mod_out)
   );

   assign busy = send_w;

   // R8: a frame only ends on a bit boundary
   p_end_on_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(bit_end_w));

   // R11: a frame only begins on a carrier edge
   p_begin_on_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(edge_w));

endmodule

// File: tb/bpsk_reply_tx_test.sv
module bpsk_reply_tx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       carrier = 1'b0;
   logic       start = 1'b0;
   logic [7:0] status_in = 8'h00;
   logic [7:0] count_in = 8'h00;
   logic [7:0] byte_data;
   logic       byte_req, busy, mod_out;

   logic [7:0] bytes [0:15];
   int idx = 0;
   int reqs = 0;
   bit req_seen = 1'b0;
   int errors = 0;
   int checks = 0;

   assign byte_data = bytes[idx];

   bpsk_reply_tx uut (
      .clk(clk), .rst_n(rst_n), .carrier_in(carrier), .start(start),
      .status_in(status_in), .count_in(count_in), .byte_data(byte_data),
      .byte_req(byte_req), .busy(busy), .mod_out(mod_out)
   );

   always #5 clk = ~clk;

   initial begin
      forever begin
         repeat (4) @(posedge clk);
         carrier <= ~carrier;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (req_seen) begin
         idx++;
         req_seen = 1'b0;
      end
      if (byte_req) begin
         reqs++;
         req_seen = 1'b1;
      end
   endtask

   task automatic run_frame(input logic [7:0] st, input int cnt, input bit poke);
      bit exp_bits [0:255];
      int nb = 0;
      int lat = 0;
      int mism = 0, incons = 0, drop = 0, stray = 0;
      logic s0, s1, s15;
      s0 = 1'b0; s1 = 1'b0; s15 = 1'b0;
      for (int i = 0; i < 8; i++) exp_bits[nb++] = st[i];
      if (st == 8'h00) begin
         for (int b = 0; b < cnt; b++) begin
            exp_bits[nb++] = 1'b0;
            for (int i = 0; i < 8; i++) exp_bits[nb++] = bytes[b][i];
            exp_bits[nb++] = ^bytes[b];
            exp_bits[nb++] = 1'b1;
         end
      end
      idx = 0; reqs = 0; req_seen = 1'b0;
      status_in = st; count_in = 8'(cnt);
      start = 1'b1;
      tick();
      start = 1'b0;
      while (!busy && lat < 40) begin
         tick();
         lat++;
      end
      check(busy && lat <= 16, "R11 frame launch latency", lat, 16);
      for (int k = 0; k < nb; k++) begin
         for (int m = 0; m < 128; m++) begin
            if (m == 2)   s0  = mod_out;
            if (m == 10)  s1  = mod_out;
            if (m == 122) s15 = mod_out;
            if (!busy) drop++;
            if (poke && k == 3 && m == 50) begin
               start = 1'b1; status_in = 8'h55; count_in = 8'd9;
            end
            if (poke && k == 3 && m == 51) start = 1'b0;
            tick();
         end
         if (s1 != ~s0 || s15 != ~s0) incons++;
         if (~s0 != exp_bits[k]) begin
            if (mism == 0)
               $display("  bit %0d decoded %0d expected %0d", k, ~s0, exp_bits[k]);
            mism++;
         end
      end
      check(mism == 0, "R3/R4/R5 decoded bit stream", mism, 0);
      check(incons == 0, "R1/R2 reply carrier toggling within bit", incons, 0);
      check(drop == 0, "R8 busy held through frame", drop, 0);
      check(!busy, "R8 busy falls after last bit", busy, 0);
      if (st != 8'h00)
         check(reqs == 0, "R6 no byte request on fault status", reqs, 0);
      else
         check(reqs == cnt, "R9 byte request count", reqs, cnt);
      for (int m = 0; m < 300; m++) begin
         if (busy || mod_out || byte_req) stray++;
         tick();
      end
      if (poke)
         check(stray == 0, "R10 mid-frame start left no extra frame", stray, 0);
      else
         check(stray == 0, "R8 quiet output after frame", stray, 0);
   endtask

   task automatic test_reset();
      tick();
      check(!busy && !mod_out && !byte_req, "R12 outputs low in reset",
            int'({busy, mod_out, byte_req}), 0);
      rst_n = 1'b1;
      repeat (20) tick();
      check(!busy && !mod_out && !byte_req, "R12 outputs low after reset",
            int'({busy, mod_out, byte_req}), 0);
   endtask

   task automatic test_ok_payload();
      bytes[0] = 8'h3C; bytes[1] = 8'hA5; bytes[2] = 8'h01;
      run_frame(8'h00, 3, 1'b0);   // R5 R9
   endtask

   task automatic test_status_only();
      run_frame(8'h00, 0, 1'b0);   // R7
   endtask

   task automatic test_fault_status();
      bytes[0] = 8'hFF;
      run_frame(8'h84, 4, 1'b0);   // R6
      run_frame(8'h01, 0, 1'b0);   // R4
   endtask

   task automatic test_start_while_busy();
      bytes[0] = 8'hFF; bytes[1] = 8'h00;
      run_frame(8'h00, 2, 1'b1);   // R10
   endtask

   initial begin
      for (int i = 0; i < 16; i++) bytes[i] = 8'(i * 37 + 5);
      test_reset();
      test_ok_payload();
      test_status_only();
      test_fault_status();
      test_start_while_busy();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule